// File: doc/BRIEF.md
# Random Delay and Target Selector

This block supplies the two chance quantities of a reaction game. A free-running 4-bit linear feedback shift register steps on every system clock. When a start pulse arrives, the register's current value is folded modulo 7 into a wait of zero to six seconds. That wait is loaded into a down-counter that steps only on a one-cycle 1 Hz tick. When the count reaches zero the block raises a sticky done flag, which is the moment the player's LED should light.

The same shift register also picks which LED the player must answer. On every 1 Hz tick its value is folded modulo 8 and offset by two, so the target moves among LED positions 2 to 9 while the player is reacting. The target is presented both as a binary index and as a 10-bit one-hot LED vector. The vector is dark until done is high, and its two lowest bits never light. An abort input cancels a pending wait or clears a raised done flag. Display of times and scores belongs to other blocks.

Top module: `rand_delay_target`

## Requirements
- R1: In reset and right after it, done_o is 0, target_o is 2 and led_o is all zeros. The shift register is seeded with 4'b0001, so the first tick after reset sets target_o to 3.
- R2: The shift register steps on every clock after reset as next = {q[2:0], q[3]^q[2]} (polynomial x^4+x^3+1). It is never zero, and it repeats every 15 clocks.
- R3: A start pulse loads count = q mod 7, where q is the register value at that clock edge, and clears done_o. The count decrements only on clocks where tick_1hz_i is high. done_o stays 0 through the edge of the count-th tick.
- R4: When the loaded or remaining count is zero, done_o rises at the first clock edge that follows. With a loaded value of 0, that edge is the one right after the start edge.
- R5: A tick in the same cycle as start does not decrement. The full loaded count still needs that many further ticks.
- R6: Once high, done_o stays high across ticks and idle cycles until the next start or abort. A start while done_o is high clears it at that edge and begins a new wait.
- R7: Abort has priority over start. At the edge where abort_i is high, the count and done_o are cleared and the wait is cancelled, so later ticks never raise done_o.
- R8: At each edge with tick_1hz_i high, target_o becomes (q mod 8) + 2, a binary value from 2 to 9. It holds its value between ticks.
- R9: One clock after done_o and target_o, led_o equals the one-hot vector with bit target_o set while done_o was high, and all zeros otherwise. Bits 0 and 1 are never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz_i | input | 1 | One-cycle pulse once per second |
| start_i | input | 1 | Load a new random wait and arm the counter |
| abort_i | input | 1 | Cancel the wait and clear done |
| done_o | output | 1 | Wait has elapsed (sticky) |
| target_o | output | 4 | Binary index of the target LED, 2 to 9 |
| led_o | output | 10 | One-hot target LED vector, gated by done |

## Verification
The embedded assertions check the following on every cycle:
- the shift register never locks at zero;
- the count holds between ticks;
- done rises once an armed count is zero;
- done stays high until start or abort;
- abort leaves the counter idle;
- the target stays between 2 and 9 and changes only on ticks;
- the LED vector is at most one-hot, never lights its low two bits, and goes dark after done falls.

Only the directed scenarios can show the following, because they follow the stated polynomial through time and compare against a model:
- the exact seeded sequence;
- that each loaded wait equals the register value mod 7 at the start edge;
- the exact tick count until done, including a zero wait and a tick that coincides with the load;
- the target value chosen at each tick.

// File: rtl/rdt_pkg.sv
package rdt_pkg;
  // Two-state control for the seconds down-counter
  typedef enum logic {
    CNT_IDLE  = 1'b0,
    CNT_ARMED = 1'b1
  } cnt_state_e;
endpackage

// File: rtl/rdt_lfsr.sv
module rdt_lfsr #(
  parameter int             W    = 4,
  parameter logic [W-1:0]   TAPS = 4'b1100,
  parameter logic [W-1:0]   SEED = 4'b0001
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;
  logic         fb;

  // Fibonacci feedback: XOR of the tapped stages
  assign fb = ^(q_q & TAPS);

  always_ff @(posedge clk) begin
    if (rst) q_q <= SEED;
    else     q_q <= {q_q[W-2:0], fb};
  end

  assign q_o = q_q;

  // A nonzero seed plus a maximal polynomial must never reach all zeros
  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (rst)
    q_q != '0);
  // Each step shifts the low stages up by one place
  assert_lfsr_shift_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> q_q[W-1:1] == $past(q_q[W-2:0]));
endmodule

// File: rtl/rdt_delay_counter.sv
module rdt_delay_counter
  import rdt_pkg::*;
#(
  parameter int RND_W     = 4,
  parameter int DELAY_MOD = 7,
  parameter int CNT_W     = (DELAY_MOD > 1) ? $clog2(DELAY_MOD) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [RND_W-1:0] rnd_i,
  output logic             done_o
);
  cnt_state_e       state_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] load_val;
  logic             done_q;

  // Fold the random value into a whole-second wait
  assign load_val = CNT_W'(32'(rnd_i) % DELAY_MOD);

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      state_q <= CNT_IDLE;
      count_q <= '0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      state_q <= CNT_ARMED;
      count_q <= load_val;
      done_q  <= 1'b0;
    end else if (state_q == CNT_ARMED) begin
      if (count_q == '0) begin
        done_q  <= 1'b1;
        state_q <= CNT_IDLE;
      end else if (tick_i) begin
        count_q <= count_q - CNT_W'(1);
      end
    end
  end

  assign done_o = done_q;

  // R3: an armed, nonzero count moves only on a tick
  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == CNT_ARMED && count_q != '0 && !tick_i && !start_i && !abort_i)
      |=> $stable(count_q));
  // R4: a zero count raises done at the next edge
  assert_done_at_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == CNT_ARMED && count_q == '0 && !start_i && !abort_i) |=> done_q);
  // R6: done is sticky until start or abort
  assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (done_q && !start_i && !abort_i) |=> done_q);
  // R7: abort leaves the counter idle and cleared
  assert_abort_clears_R7: assert property (@(posedge clk) disable iff (rst)
    abort_i |=> (!done_q && count_q == '0 && state_q == CNT_IDLE));
endmodule

// File: rtl/rdt_target_sel.sv
module rdt_target_sel #(
  parameter int RND_W      = 4,
  parameter int TGT_SPAN   = 8,
  parameter int TGT_OFFSET = 2,
  parameter int IDX_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic [RND_W-1:0] rnd_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] pick;

  assign pick = IDX_W'(32'(rnd_i) % TGT_SPAN) + IDX_W'(TGT_OFFSET);

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= IDX_W'(TGT_OFFSET);
    else if (tick_i) idx_q <= pick;
  end

  assign idx_o = idx_q;

  assert_target_range_R8: assert property (@(posedge clk) disable iff (rst)
    (32'(idx_q) >= TGT_OFFSET) && (32'(idx_q) < TGT_OFFSET + TGT_SPAN));
  assert_target_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(idx_q));
endmodule

// File: rtl/rdt_led_decoder.sv
module rdt_led_decoder #(
  parameter int NUM_LEDS   = 10,
  parameter int TGT_OFFSET = 2,
  parameter int IDX_W      = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic [NUM_LEDS-1:0] led_o
);
  logic [NUM_LEDS-1:0] led_q;

  always_ff @(posedge clk) begin
    if (rst)       led_q <= '0;
    else if (en_i) led_q <= NUM_LEDS'(1) << idx_i;
    else           led_q <= '0;
  end

  assign led_o = led_q;

  assert_led_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(led_q));
  assert_led_low_dark_R9: assert property (@(posedge clk) disable iff (rst)
    led_q[TGT_OFFSET-1:0] == '0);
  assert_led_follows_en_R9: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> led_q == '0);
endmodule

// File: rtl/rand_delay_target.sv
module rand_delay_target #(
  parameter int           RND_W      = 4,
  parameter logic [3:0]   RND_TAPS   = 4'b1100,
  parameter logic [3:0]   RND_SEED   = 4'b0001,
  parameter int           DELAY_MOD  = 7,
  parameter int           TGT_SPAN   = 8,
  parameter int           TGT_OFFSET = 2,
  parameter int           NUM_LEDS   = 10,
  parameter int           IDX_W      = $clog2(NUM_LEDS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_1hz_i,
  input  logic                start_i,
  input  logic                abort_i,
  output logic                done_o,
  output logic [IDX_W-1:0]    target_o,
  output logic [NUM_LEDS-1:0] led_o
);
  localparam int CNT_W = (DELAY_MOD > 1) ? $clog2(DELAY_MOD) : 1;

  logic [RND_W-1:0] rnd;
  logic             done;
  logic [IDX_W-1:0] idx;

  rdt_lfsr #(.W(RND_W), .TAPS(RND_TAPS), .SEED(RND_SEED)) u_lfsr (
    .clk(clk), .rst(rst), .q_o(rnd)
  );

  rdt_delay_counter #(.RND_W(RND_W), .DELAY_MOD(DELAY_MOD), .CNT_W(CNT_W)) u_delay (
    .clk(clk), .rst(rst), .tick_i(tick_1hz_i), .start_i(start_i),
    .abort_i(abort_i), .rnd_i(rnd), .done_o(done)
  );

  rdt_target_sel #(.RND_W(RND_W), .TGT_SPAN(TGT_SPAN),
                   .TGT_OFFSET(TGT_OFFSET), .IDX_W(IDX_W)) u_target (
    .clk(clk), .rst(rst), .tick_i(tick_1hz_i), .rnd_i(rnd), .idx_o(idx)
  );

  rdt_led_decoder #(.NUM_LEDS(NUM_LEDS), .TGT_OFFSET(TGT_OFFSET),
                    .IDX_W(IDX_W)) u_leds (
    .clk(clk), .rst(rst), .en_i(done), .idx_i(idx), .led_o(led_o)
  );

  assign done_o   = done;
  assign target_o = idx;
endmodule

// File: tb/tb_rand_delay_target.sv
module tb_rand_delay_target;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, start = 1'b0, abort = 1'b0;
  logic       done;
  logic [3:0] target;
  logic [9:0] led;

  int         total = 0, fails = 0;
  logic [3:0] m = 4'b0001;   // model of the shift register
  logic [3:0] m_tgt = 4'd2;  // model of the target index

  always #(CLK_P/2) clk = ~clk;

  rand_delay_target dut (
    .clk(clk), .rst(rst), .tick_1hz_i(tick), .start_i(start),
    .abort_i(abort), .done_o(done), .target_o(target), .led_o(led)
  );

  function automatic logic [3:0] nx(input logic [3:0] v);
    return {v[2:0], v[3] ^ v[2]};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: model follows the edge, return at the falling edge
  task automatic cyc();
    @(posedge clk);
    if (!rst) begin
      if (tick) m_tgt = 4'((int'(m) % 8) + 2);
      m = nx(m);
    end
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; cyc(); tick = 1'b0;
  endtask

  task automatic wait_mod(input int want);
    while (int'(m) % 7 != want) cyc();
  endtask

  // Runs d ticks after a load, checking done low, then done high
  task automatic count_out(input int d, input string req);
    for (int k = 0; k < d; k++) begin
      cyc(); chk(req, done, 0);
      pulse_tick(); chk(req, done, 0);
    end
    cyc(); chk(req, done, 1);
    chk("R9 led dark on rise", led, 0);
    cyc(); chk("R9 led one-hot", led, 1 << m_tgt);
    chk("R8 target", target, m_tgt);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 done", done, 0);
    chk("R1 target", target, 2);
    chk("R1 led", led, 0);
    rst = 1'b0; m = 4'b0001; m_tgt = 4'd2;
    pulse_tick();
    chk("R1 seed target", target, 3);
  endtask

  task automatic t_target_walk();
    for (int k = 0; k < 20; k++) begin
      for (int j = 0; j < k % 3; j++) begin
        cyc(); chk("R8 hold", target, m_tgt);
      end
      pulse_tick();
      chk("R2 R8 target", target, m_tgt);
      chk("R9 led dark idle", led, 0);
    end
  endtask

  task automatic t_delay(input int want, input string req);
    int d;
    wait_mod(want);
    d = int'(m) % 7;
    start = 1'b1; cyc(); start = 1'b0;
    chk(req, done, 0);
    count_out(d, req);
  endtask

  task automatic t_hold_restart();
    for (int k = 0; k < 3; k++) begin
      pulse_tick(); chk("R6 sticky", done, 1);
      cyc(); chk("R9 led tracks", led, 1 << m_tgt);
    end
    wait_mod(5);
    start = 1'b1; cyc(); start = 1'b0;
    chk("R6 restart clears", done, 0);
    cyc(); chk("R9 led off after restart", led, 0);
    abort = 1'b1; cyc(); abort = 1'b0;
  endtask

  task automatic t_abort();
    wait_mod(4);
    start = 1'b1; cyc(); start = 1'b0;
    pulse_tick();
    abort = 1'b1; start = 1'b1; cyc(); abort = 1'b0; start = 1'b0;
    chk("R7 abort", done, 0);
    for (int k = 0; k < 10; k++) begin
      pulse_tick(); cyc();
      chk("R7 stays cancelled", done, 0);
    end
    t_delay(2, "R3 before abort");
    abort = 1'b1; cyc(); abort = 1'b0;
    chk("R7 abort clears done", done, 0);
    cyc(); chk("R7 R9 led off", led, 0);
  endtask

  task automatic t_tick_on_load();
    wait_mod(3);
    start = 1'b1; tick = 1'b1; cyc(); start = 1'b0; tick = 1'b0;
    chk("R5", done, 0);
    pulse_tick(); pulse_tick();
    cyc(); chk("R5 not early", done, 0);
    pulse_tick(); chk("R5", done, 0);
    cyc(); chk("R5 done", done, 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_target_walk();
    t_delay(0, "R4 zero wait");
    t_delay(6, "R3 six seconds");
    t_hold_restart();
    t_delay(3, "R3 three seconds");
    t_abort();
    t_tick_on_load();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule